// File: doc/BRIEF.md
# Single-Slot Interrupt Deliverer

This block hands an external interrupt request to the core. When a request arrives while the core's interrupt-enable bit is set, the block takes the interrupt on that tick. It copies the current PC and status word into backup registers, drives a zeroed status word, redirects the program counter to a fixed vector and pulses a strobe that asks the neighbouring logic to swap stack pointers. The stack swap itself is done elsewhere.

When interrupts are masked, the block keeps one request in a single pending slot. It retries that request on every following tick and delivers it on the first tick in which the enable bit is high. While the slot is occupied, any further requests are discarded. The PC output normally follows the core's next-PC one cycle later. A delivery overrides it for that one cycle.

All outputs are registered, so a delivery decided on one clock edge appears on the outputs after that edge.

Top module: `irq_deliver`

## Requirements
- R1: After a synchronous reset, the outputs `redirect_valid_o`, `stack_swap_o`, `backup_pc_o`, `backup_status_o`, `status_o` and `pc_o` are all zero, and the pending slot is empty.
- R2: A request (`irq_req_i`=1) sampled with `int_en_i`=1 gives `redirect_valid_o`=1 and `pc_o`=VECTOR (default 0xFFFFF138) in the next cycle. For each tick that delivers, `redirect_valid_o` is high for exactly that one cycle.
- R3: On a delivery, `backup_pc_o` and `backup_status_o` take the `cur_pc_i` and `cur_status_i` values sampled on the delivering tick. At all other times they hold their value.
- R4: In a delivery cycle `status_o` is zero. In every other cycle `status_o` equals `cur_status_i` from the previous tick.
- R5: `stack_swap_o` pulses high in exactly the cycles in which `redirect_valid_o` is high.
- R6: When there is no delivery, `pc_o` equals `next_pc_i` from the previous tick.
- R7: A request sampled with `int_en_i`=0 causes no delivery and is held in the pending slot. It is delivered on the first later tick with `int_en_i`=1, even if no new request arrives on that tick.
- R8: Requests that arrive with `int_en_i`=0 while a request is already pending are discarded. Any number of masked requests leads to exactly one delivery once the enable bit is set.
- R9: A new request on the same tick as a pending request, with `int_en_i`=1, leads to one delivery, and the slot is empty afterwards.
- R10: Reset empties the pending slot. A request held before reset is never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | External interrupt request, one request per high cycle |
| int_en_i | input | 1 | Interrupt-enable bit from the core's status word |
| cur_pc_i | input | PC_W | PC of the current instruction |
| cur_status_i | input | ST_W | Current status word |
| next_pc_i | input | PC_W | Core's normal next-PC |
| redirect_valid_o | output | 1 | One-cycle pulse marking a delivery |
| pc_o | output | PC_W | Next PC: the vector on delivery, otherwise the registered next_pc_i |
| backup_pc_o | output | PC_W | PC saved at the last delivery |
| backup_status_o | output | ST_W | Status word saved at the last delivery |
| status_o | output | ST_W | Next status word: zero on delivery, otherwise the registered cur_status_i |
| stack_swap_o | output | 1 | Stack-pointer swap request pulse |

## Verification
The deliverer is tried with the following input patterns:
- Single enabled requests. These separate immediate delivery from deferred delivery.
- A masked request followed by a later enable with no new request. This shows whether the pending slot retries on its own.
- Bursts of masked requests. A count of exactly one delivery separates a single slot from one that counts or queues.
- A pending request colliding with a new enabled request. This exposes a double delivery.
- A reset between masking and enabling. This shows whether reset empties the slot.

A long stretch of random requests, enables, PCs and status words is compared on every clock against a behavioural model. This model catches capture-timing errors in the backup registers and in the pass-through PC and status.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_HELD  = 1'b1
  } slot_e;
endpackage

// File: rtl/irqd_slot.sv
module irqd_slot
  import irqd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic en_i,
  output logic fire_o,
  output logic held_o
);
  slot_e slot_q;

  assign held_o = (slot_q == SLOT_HELD);
  // a held request retries every tick until the enable bit lets it through
  assign fire_o = en_i & (req_i | held_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= SLOT_EMPTY;
    end else if (en_i) begin
      slot_q <= SLOT_EMPTY;
    end else if (req_i) begin
      slot_q <= SLOT_HELD;   // a request arriving while held is dropped
    end
  end

  AST_SLOT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (held_o && !en_i) |=> held_o); // R8
  AST_SLOT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    en_i |=> !held_o); // R9
  AST_SLOT_FILLS: assert property (@(posedge clk) disable iff (rst)
    (req_i && !en_i) |=> held_o); // R7
endmodule

// File: rtl/irqd_capture.sv
module irqd_capture #(
  parameter int PC_W = 32,
  parameter int ST_W = 32,
  parameter logic [PC_W-1:0] VECTOR = 'hFFFFF138
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire_i,
  input  logic [PC_W-1:0] cur_pc_i,
  input  logic [ST_W-1:0] cur_status_i,
  input  logic [PC_W-1:0] next_pc_i,
  output logic            redirect_valid_o,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] backup_pc_o,
  output logic [ST_W-1:0] backup_status_o,
  output logic [ST_W-1:0] status_o,
  output logic            stack_swap_o
);
  localparam logic [ST_W-1:0] ST_CLEAR = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid_o <= 1'b0;
      stack_swap_o     <= 1'b0;
      pc_o             <= '0;
      status_o         <= '0;
      backup_pc_o      <= '0;
      backup_status_o  <= '0;
    end else begin
      redirect_valid_o <= fire_i;
      stack_swap_o     <= fire_i;
      pc_o             <= fire_i ? VECTOR : next_pc_i;
      status_o         <= fire_i ? ST_CLEAR : cur_status_i;
      if (fire_i) begin
        backup_pc_o     <= cur_pc_i;
        backup_status_o <= cur_status_i;
      end
    end
  end

  AST_BACKUP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fire_i |=> $stable(backup_pc_o) && $stable(backup_status_o)); // R3
  AST_PASS_PC: assert property (@(posedge clk) disable iff (rst)
    !fire_i |=> pc_o == $past(next_pc_i)); // R6
endmodule

// File: rtl/irq_deliver.sv
module irq_deliver #(
  parameter int PC_W = 32,
  parameter int ST_W = 32,
  parameter logic [PC_W-1:0] VECTOR = 'hFFFFF138
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq_req_i,
  input  logic            int_en_i,
  input  logic [PC_W-1:0] cur_pc_i,
  input  logic [ST_W-1:0] cur_status_i,
  input  logic [PC_W-1:0] next_pc_i,
  output logic            redirect_valid_o,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] backup_pc_o,
  output logic [ST_W-1:0] backup_status_o,
  output logic [ST_W-1:0] status_o,
  output logic            stack_swap_o
);
  logic fire;
  logic held;

  irqd_slot i_slot (
    .clk    (clk),
    .rst    (rst),
    .req_i  (irq_req_i),
    .en_i   (int_en_i),
    .fire_o (fire),
    .held_o (held)
  );

  irqd_capture #(
    .PC_W   (PC_W),
    .ST_W   (ST_W),
    .VECTOR (VECTOR)
  ) i_capture (
    .clk              (clk),
    .rst              (rst),
    .fire_i           (fire),
    .cur_pc_i         (cur_pc_i),
    .cur_status_i     (cur_status_i),
    .next_pc_i        (next_pc_i),
    .redirect_valid_o (redirect_valid_o),
    .pc_o             (pc_o),
    .backup_pc_o      (backup_pc_o),
    .backup_status_o  (backup_status_o),
    .status_o         (status_o),
    .stack_swap_o     (stack_swap_o)
  );

  AST_DELIVER_NOW: assert property (@(posedge clk) disable iff (rst)
    (irq_req_i && int_en_i) |=> (redirect_valid_o && pc_o == VECTOR)); // R2
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !int_en_i |=> !redirect_valid_o); // R7
  AST_RETRY_HELD: assert property (@(posedge clk) disable iff (rst)
    (held && int_en_i) |=> redirect_valid_o); // R7
  AST_BACKUP_PC: assert property (@(posedge clk) disable iff (rst)
    (irq_req_i && int_en_i) |=> backup_pc_o == $past(cur_pc_i)); // R3
  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    redirect_valid_o |-> status_o == '0); // R4
  AST_SWAP_PULSE: assert property (@(posedge clk) disable iff (rst)
    (irq_req_i && int_en_i) |=> stack_swap_o); // R5
endmodule

// File: tb/test_irq_deliver.sv
`timescale 1ns/1ps
module test_irq_deliver;
  localparam logic [31:0] VEC = 32'hFFFFF138;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req = 1'b0;
  logic        int_en = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [31:0] cur_st = '0;
  logic [31:0] nxt_pc = '0;
  logic        rv, swp;
  logic [31:0] pc_o, bpc, bst, st_o;

  always #2 clk = ~clk;

  irq_deliver i_irq_deliver (
    .clk (clk), .rst (rst), .irq_req_i (irq_req), .int_en_i (int_en),
    .cur_pc_i (cur_pc), .cur_status_i (cur_st), .next_pc_i (nxt_pc),
    .redirect_valid_o (rv), .pc_o (pc_o), .backup_pc_o (bpc),
    .backup_status_o (bst), .status_o (st_o), .stack_swap_o (swp)
  );

  integer checks = 0;
  integer errors = 0;
  integer deliv = 0;
  bit     armed = 0;

  // behavioural reference
  bit          m_pend, m_rv;
  logic [31:0] m_pc, m_bpc, m_bst, m_st;
  always @(posedge clk) begin
    if (rst) begin
      m_pend <= 0; m_rv <= 0; m_pc <= 0; m_bpc <= 0; m_bst <= 0; m_st <= 0;
    end else begin
      if (int_en && (irq_req || m_pend)) begin
        m_rv <= 1; m_pc <= VEC; m_st <= 0; m_bpc <= cur_pc; m_bst <= cur_st;
        m_pend <= 0;
      end else begin
        m_rv <= 0; m_pc <= nxt_pc; m_st <= cur_st;
        if (int_en) m_pend <= 0;
        else if (irq_req) m_pend <= 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    if (armed) begin
      check("R2 redirect_valid", {31'd0, rv}, {31'd0, m_rv});
      check("R6 pc_o", pc_o, m_pc);
      check("R3 backup_pc", bpc, m_bpc);
      check("R3 backup_status", bst, m_bst);
      check("R4 status_o", st_o, m_st);
      check("R5 stack_swap", {31'd0, swp}, {31'd0, m_rv});
      if (rv === 1'b1) deliv++;
    end
  endtask

  task automatic step(input bit rq, input bit en, input logic [31:0] pc,
                      input logic [31:0] st, input logic [31:0] np);
    @(negedge clk);
    compare();
    irq_req = rq; int_en = en; cur_pc = pc; cur_st = st; nxt_pc = np;
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare();
    rst = 1; irq_req = 0; int_en = 0;
    @(negedge clk);
    rst = 0;
    armed = 1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    integer d0;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    armed = 1;
    // R1: reset state
    check("R1 rv after reset", {31'd0, rv}, 32'd0);
    check("R1 pc after reset", pc_o, 32'd0);
    check("R1 backup after reset", bpc | bst, 32'd0);
    check("R1 swap after reset", {31'd0, swp}, 32'd0);
    step(0, 1, 32'h100, 32'h55, 32'h108);
    step(0, 1, 32'h108, 32'h55, 32'h110);
    @(negedge clk);
    check("R1 no delivery from empty slot", {31'd0, rv}, 32'd0);

    // R2 R3 R4 R5: single enabled request
    step(1, 1, 32'h2000, 32'hA5A5, 32'h2008);
    step(0, 1, 32'h2008, 32'h1111, 32'h2010);
    @(negedge clk);
    // values seen here are after the post-request edge handled by step's compare
    check("R3 backup_pc captured", bpc, 32'h2000);
    check("R3 backup_status captured", bst, 32'hA5A5);

    // R7: masked request retried later without a new request
    d0 = deliv;
    step(1, 0, 32'h3000, 32'h7, 32'h3008);
    step(0, 0, 32'h3008, 32'h7, 32'h3010);
    step(0, 0, 32'h3010, 32'h7, 32'h3018);
    step(0, 1, 32'h3018, 32'h9, 32'h3020);
    step(0, 1, 32'h3020, 32'h9, 32'h3028);
    step(0, 1, 32'h3028, 32'h9, 32'h3030);
    check("R7 masked request delivered once", deliv - d0, 32'd1);
    check("R7 backup pc from retry tick", bpc, 32'h3018);

    // R8: burst of masked requests
    d0 = deliv;
    step(1, 0, 32'h400, 32'h1, 32'h408);
    step(1, 0, 32'h408, 32'h2, 32'h410);
    step(0, 0, 32'h410, 32'h3, 32'h418);
    step(1, 0, 32'h418, 32'h4, 32'h420);
    step(0, 1, 32'h420, 32'h5, 32'h428);
    step(0, 1, 32'h428, 32'h6, 32'h430);
    step(0, 1, 32'h430, 32'h6, 32'h438);
    check("R8 one delivery from burst", deliv - d0, 32'd1);

    // R9: pending plus new request on enable tick
    d0 = deliv;
    step(1, 0, 32'h500, 32'h1, 32'h508);
    step(1, 1, 32'h508, 32'h2, 32'h510);
    step(0, 1, 32'h510, 32'h3, 32'h518);
    step(0, 1, 32'h518, 32'h3, 32'h520);
    check("R9 single delivery on collision", deliv - d0, 32'd1);

    // R10: reset empties the slot
    step(1, 0, 32'h600, 32'h1, 32'h608);
    do_reset();
    d0 = deliv;
    step(0, 1, 32'h700, 32'h1, 32'h708);
    step(0, 1, 32'h708, 32'h1, 32'h710);
    step(0, 1, 32'h710, 32'h1, 32'h718);
    check("R10 no delivery after reset", deliv - d0, 32'd0);

    // R2: back-to-back enabled requests
    d0 = deliv;
    step(1, 1, 32'h800, 32'h1, 32'h808);
    step(1, 1, 32'h808, 32'h2, 32'h810);
    step(0, 1, 32'h810, 32'h3, 32'h818);
    step(0, 1, 32'h818, 32'h3, 32'h820);
    check("R2 two deliveries back to back", deliv - d0, 32'd2);

    // random patterns against the model
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, ($urandom % 3) == 0, $urandom, $urandom, $urandom);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule